// File: doc/BRIEF.md
# Burst Termination Data Path

This block is the device-side data path of a synchronous DRAM column interface. It accepts a registered command each clock, runs read and write bursts over a small behavioural word store, and lets a burst-stop command cut a burst short. Read words leave on the data output after a programmable CAS latency. Write words are taken from the data input starting in the same cycle as the write command.

A read burst and a write burst react to a stop in different cycles. On a read, the stop halts the address sequencer at once. Words already in the latency pipeline still drain, so the output falls silent exactly CAS-latency edges after the stop. On a write, the data presented with the stop, and all data after it, is discarded. Burst length is programmable from a single word up to a full page of the store. Column addresses advance and wrap inside the aligned burst block.

Top module: `burst_dpath`

## Requirements
- R1: The CAS latency is taken from `cas_lat_i` and may be 1, 2 or 3 edges. The value 0 is not a legal setting.
- R2: When READ is sampled at edge E, burst word k is on `dq_o`, with `dq_oe_o` high, in the cycle that follows edge E+CL+k.
- R3: The `burst_len_i` codes select the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give a full page of 2^AW words (32 by default).
- R4: When WRITE is sampled at edge E, the word on `dq_i` at edge E is stored at the start column. Burst word t is taken from `dq_i` at edge E+t.
- R5: When BURST STOP is sampled at edge S during a read burst, every word fetched before S is still driven. `dq_oe_o` is low after edge S+CL.
- R6: When BURST STOP is sampled at edge S during a write burst, the data on `dq_i` at edge S is not stored, and neither is the data at any later edge of that burst.
- R7: After the last word of a read burst, `dq_oe_o` falls in the next cycle. While `dq_oe_o` is low, `dq_o` is all zeros.
- R8: Burst word k uses column (start & ~(BL-1)) | ((start + k) & (BL-1)). The address wraps inside the aligned block of BL words.
- R9: Command codes on `cmd_i` are: 0 NOP, 1 DESELECT, 2 READ, 3 WRITE, 4 BURST STOP. Codes 5 to 7 act as NOP. A NOP or DESELECT issued during a burst does not change that burst.
- R10: While `rst_n` is low, `dq_oe_o` is low and no burst is active. A read in progress when reset is applied produces no further output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Registered command code |
| col_i | input | AW (5) | Start column of a READ or WRITE |
| cas_lat_i | input | 2 | CAS latency, 1 to 3 |
| burst_len_i | input | 3 | Burst length code |
| dq_i | input | DW (16) | Write data |
| dq_o | output | DW (16) | Read data, zero when not driven |
| dq_oe_o | output | 1 | Read data valid, standing in for the output driver enable |

## Verification
The assertions assume that `cas_lat_i` is never 0. They also assume that the latency and burst-length settings do not change while a burst or its latency pipeline is in flight. The stimulus sets both before each command and holds them until the burst has fully drained. It also never issues a new READ or WRITE before the previous burst has finished, so the assertions are exercised only on isolated bursts.

Within those limits, the stimulus walks a table that covers every latency, several burst lengths, and start columns that force wrapping. Some table entries include stops, timed at the first word, mid-burst and at the wrap point. Directed write bursts mix NOP and DESELECT into their gaps and are read back against a model of the store.

// File: rtl/burst_dpath_pkg.sv
package burst_dpath_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_BSTOP = 3'd4
  } cmd_e;

  localparam int unsigned BLC_W = 3;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_dpath_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [AW-1:0]     col_i,
  input  logic [BLC_W-1:0]  blen_i,
  output logic              rd_emit_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o
);

  logic          act_q, act_n;
  logic          rd_q, rd_n;
  logic [AW-1:0] base_q, base_n;
  logic [AW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] mask_q, mask_n;
  logic [AW-1:0] new_mask;
  logic [AW-1:0] cur_addr;
  logic          is_rd, is_wr, is_stop, start, seq_en;

  assign is_rd   = (cmd_i == CMD_READ);
  assign is_wr   = (cmd_i == CMD_WRITE);
  assign is_stop = (cmd_i == CMD_BSTOP);
  assign start   = is_rd | is_wr;
  assign seq_en  = start | act_q;

  // Length code to column mask; codes 4 and above select the full page.
  always_comb begin
    if (blen_i[2]) new_mask = '1;
    else           new_mask = (AW'(1) << blen_i[1:0]) - AW'(1);
  end

  // Column within the aligned burst block.
  assign cur_addr = (base_q & ~mask_q) | ((base_q + cnt_q) & mask_q);

  always_comb begin
    act_n  = act_q;
    rd_n   = rd_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    mask_n = mask_q;
    if (start) begin
      rd_n   = is_rd;
      base_n = col_i;
      mask_n = new_mask;
      // A write consumes word 0 at the command edge itself.
      cnt_n  = is_rd ? '0 : AW'(1);
      act_n  = is_rd | (new_mask != '0);
    end else if (act_q) begin
      if (is_stop || (cnt_q == mask_q)) act_n = 1'b0;
      else                              cnt_n = cnt_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (seq_en) begin
      act_q <= act_n;
    end
  end

  always_ff @(posedge clk) begin
    if (seq_en) begin
      rd_q   <= rd_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
      mask_q <= mask_n;
    end
  end

  assign rd_emit_o = act_q & rd_q;
  assign rd_addr_o = cur_addr;
  assign wr_en_o   = is_wr | (act_q & ~rd_q & ~is_stop & ~start);
  assign wr_addr_o = is_wr ? col_i : cur_addr;

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && is_stop) |=> !act_q); // R5

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ((cnt_q & ~mask_q) == '0)); // R3

endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int unsigned DW     = 16,
  parameter int unsigned CL_MAX = 3,
  localparam int unsigned CLW   = $clog2(CL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           emit_i,
  input  logic [DW-1:0]  data_i,
  input  logic [CLW-1:0] cas_lat_i,
  output logic           valid_o,
  output logic [DW-1:0]  data_o
);

  logic [CL_MAX-1:0] v_q;
  logic [DW-1:0]     d_q [CL_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q[0] <= 1'b0;
    else        v_q[0] <= emit_i;
  end

  always_ff @(posedge clk) begin
    if (emit_i) d_q[0] <= data_i;
  end

  for (genvar g = 1; g < CL_MAX; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[g] <= 1'b0;
      else        v_q[g] <= v_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (v_q[g-1]) d_q[g] <= d_q[g-1];
    end
  end

  // Tap the stage that matches the programmed latency; undriven data reads as zero.
  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    for (int i = 0; i < CL_MAX; i++) begin
      if (int'(cas_lat_i) == i + 1 && v_q[i]) begin
        valid_o = 1'b1;
        data_o  = d_q[i];
      end
    end
  end

endmodule

// File: rtl/word_array.sv
module word_array #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 5,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_dpath_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned AW     = 5,
  parameter int unsigned CL_MAX = 3,
  localparam int unsigned CLW   = $clog2(CL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [AW-1:0]    col_i,
  input  logic [CLW-1:0]   cas_lat_i,
  input  logic [BLC_W-1:0] burst_len_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);

  logic          rd_emit;
  logic [AW-1:0] rd_addr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] rd_word;

  burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .col_i     (col_i),
    .blen_i    (burst_len_i),
    .rd_emit_o (rd_emit),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr)
  );

  word_array #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (dq_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  rd_lat_pipe #(.DW(DW), .CL_MAX(CL_MAX)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit_i    (rd_emit),
    .data_i    (rd_word),
    .cas_lat_i (cas_lat_i),
    .valid_o   (dq_oe_o),
    .data_o    (dq_o)
  );

  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat_i != '0); // R1

  AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WRITE) |-> (wr_en && wr_addr == col_i)); // R4

  AST_NO_WR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_BSTOP) |-> !wr_en); // R6

  AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_READ) |=> rd_emit); // R2

endmodule

// File: tb/burst_dpath_test.sv
`timescale 1ns/1ps
module burst_dpath_test;

  localparam int DW = 16;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] C_NOP = 3'd0, C_DES = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_STP = 3'd4;

  // Vector: {cl[1:0], blen[2:0], col[4:0], stop_gap[5:0]}; gap 0 means no stop.
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd1, 3'd2, 5'd0,  6'd0},
    {2'd2, 3'd3, 5'd5,  6'd0},
    {2'd3, 3'd3, 5'd12, 6'd0},
    {2'd1, 3'd4, 5'd20, 6'd0},
    {2'd2, 3'd4, 5'd3,  6'd5},
    {2'd3, 3'd4, 5'd30, 6'd2},
    {2'd1, 3'd3, 5'd9,  6'd3},
    {2'd2, 3'd0, 5'd17, 6'd0},
    {2'd3, 3'd1, 5'd7,  6'd0},
    {2'd3, 3'd4, 5'd0,  6'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd;
  logic [AW-1:0] col;
  logic [1:0]    cl;
  logic [2:0]    blen;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  logic [DW-1:0] model [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_dpath uut (
    .clk (clk), .rst_n (rst_n), .cmd_i (cmd), .col_i (col),
    .cas_lat_i (cl), .burst_len_i (blen), .dq_i (dq_in),
    .dq_o (dq_out), .dq_oe_o (dq_oe)
  );

  function automatic int bl_of(input logic [2:0] c);
    return c[2] ? DEPTH : (1 << c[1:0]);
  endfunction

  function automatic int addr_of(input int start, input logic [2:0] c, input int k);
    int m;
    m = bl_of(c) - 1;
    return (start & ~m) | ((start + k) & m);
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Inputs change at the falling edge; outputs are sampled at the next falling edge.
  task automatic step(input logic [2:0] c, input int a, input logic [DW-1:0] d);
    cmd   = c;
    col   = AW'(a);
    dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_check(input logic [1:0] l, input logic [2:0] b, input int start, input int gap);
    int bl, n, k;
    logic ev;
    logic [DW-1:0] ed;
    cl = l; blen = b;
    bl = bl_of(b);
    n  = (gap != 0 && gap < bl) ? gap : bl;
    step(C_RD, start, '0);
    for (int t = 1; t <= int'(l) + bl + 2; t++) begin
      step((t == gap) ? C_STP : ((t % 2) ? C_DES : C_NOP), 0, '0);
      k  = t - int'(l);
      ev = (k >= 0 && k < n);
      ed = ev ? model[addr_of(start, b, k)] : '0;
      // R2/R3/R8 data order, R5 stop drain, R7 release, R9 NOP and DESELECT in gaps
      chk(gap != 0 ? "R5 read stop" : (ev ? "R2/R3/R8 read word" : "R7 read idle"),
          (dq_oe === ev) && (dq_out === ed), {15'd0, dq_oe, dq_out}, {15'd0, ev, ed});
    end
  endtask

  task automatic wr_burst(input logic [2:0] b, input int start, input int gap, input logic [DW-1:0] seed);
    int bl;
    blen = b;
    bl = bl_of(b);
    step(C_WR, start, seed);
    model[addr_of(start, b, 0)] = seed;
    for (int t = 1; t <= bl + 1; t++) begin
      step((t == gap) ? C_STP : ((t % 2) ? C_DES : C_NOP), 0, seed + DW'(t));
      // R4 accepted words; R6 words at and after the stop are dropped
      if (t < bl && (gap == 0 || t < gap)) model[addr_of(start, b, t)] = seed + DW'(t);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; cmd = C_NOP; col = '0; cl = 2'd1; blen = 3'd0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset idle", dq_oe === 1'b0 && dq_out === '0, {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    step(C_NOP, 0, '0);

    // Fill the full page (R3 code 4, R4 first word with the command).
    wr_burst(3'd4, 0, 0, 16'h1000);

    // Table walk: latencies 1..3 (R1), lengths, wrap and stop positions.
    for (int v = 0; v < NVEC; v++) begin
      rd_check(VEC[v][15:14], VEC[v][13:11], int'(VEC[v][10:6]), int'(VEC[v][5:0]));
      repeat (2) step(C_NOP, 0, '0);
    end

    // R6: stop after three words of an 8-word write, then read the block back.
    wr_burst(3'd3, 8, 3, 16'h5A00);
    rd_check(2'd1, 3'd3, 8, 0);
    chk("R6 word at stop kept old", model[11] === 16'h100B, {16'd0, model[11]}, 32'h100B);

    // R8: 4-word write from column 30 wraps to 28 and 29.
    wr_burst(3'd2, 30, 0, 16'h7700);
    rd_check(2'd2, 3'd2, 28, 0);

    // R10: reset in the middle of a read burst clears everything in flight.
    cl = 2'd3; blen = 3'd3;
    step(C_RD, 4, '0);
    step(C_NOP, 0, '0);
    step(C_NOP, 0, '0);
    step(C_NOP, 0, '0);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", dq_oe === 1'b0, {31'd0, dq_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 6; t++) begin
      step(C_NOP, 0, '0);
      chk("R10 no resume", dq_oe === 1'b0, {31'd0, dq_oe}, 32'd0);
    end

    finish_up();
  end

endmodule